// File: doc/BRIEF.md
# Time-Shared Carry Select Adder

This block is a combinational binary adder split into a low group and one or more equal upper groups. The low group is a plain ripple adder fed by the external carry-in. Each upper group has a single ripple adder instead of the usual duplicated pair, and that adder is used twice within each clock period. The clock level sets the adder's assumed carry-in.

While the clock is high, the upper-group adder assumes a carry-in of one. A level-sensitive latch, transparent in that phase, stores the group's sum and carry-out. While the clock is low, the latch is opaque and the same adder recomputes with an assumed carry-in of zero. The actual carry arriving from the group below then drives a multiplexer. A carry of one takes the latched result and a carry of zero takes the live result. The chosen carry-out of each group is the select for the next group up, and the chosen carry of the top group is the adder's carry-out.

The result is not registered. Operands and carry-in must be held from one rising clock edge to the next. Sum and carry-out are valid only at the end of the low phase, just before the next rising edge. The default build is a 22-bit low group with one 10-bit upper group. Setting the low group to 16 bits and using two 8-bit upper groups gives a three-group 32-bit build.

Top module: `ts_csel_adder`

## Requirements
- R1: Just before each rising edge, {cout, sum} equals a + b + cin computed at WIDTH+1 bits, for any operands held stable since the previous rising edge.
- R2: The low group covers bits 0 to LO_W-1 and adds them with the external carry-in. When no carry leaves the low group, its sum bits and all upper bits equal a plain addition.
- R3: While the clock is high, each upper-group latch is transparent and holds {carry-out, sum} of that group's operand slices plus one, which is HI_W+1 bits.
- R4: While the clock is low, each upper-group adder produces that group's slice sum plus zero while the latch keeps the carry-in-one result.
- R5: Each upper group outputs the latched result when the carry from the group below is 1 and the live carry-in-zero result when that carry is 0.
- R6: The selected carry-out of each upper group is the select of the next upper group, and the selected carry-out of the top group is cout.
- R7: With LO_W=16, HI_W=8 and NUM_HI=2, the adder forms a correct 32-bit sum in three groups of 16, 8 and 8 bits.
- R8: A carry chain that ends exactly at a group boundary, such as bit 22 in the default build or bits 16 and 24 in the three-group build, gives the exact sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock. High selects the assumed carry-in of one and opens the latches; low selects the assumed carry-in of zero. |
| rst_n | input | 1 | Active-low reset; qualifies the embedded checks only, because the datapath holds no reset state. |
| a | input | WIDTH | First operand, held for a full clock period. |
| b | input | WIDTH | Second operand, held for a full clock period. |
| cin | input | 1 | External carry into bit 0. |
| sum | output | WIDTH | Sum, valid at the end of the low phase. |
| cout | output | 1 | Carry out of the top group. |

## Verification
The hardest case to reach from the ports is a result that must come from the latch: an upper group whose true carry-in is one. For that result to be right, the carry-in-one value must have survived the falling edge untouched. The stimulus forces this case directly. It uses operands whose low bits are all ones, so a carry is generated inside the low group and ripples exactly to a chosen bit. That bit is swept across every position, including each group boundary. It also applies paired vectors that share the upper bits but differ only in whether the low group produces a carry, so each upper group is seen taking both multiplexer inputs.

// File: rtl/tsca_pkg.sv
package tsca_pkg;
  // total datapath width from the group split
  function automatic int total_width(input int lo_w, input int hi_w, input int n_hi);
    return lo_w + n_hi * hi_w;
  endfunction
endpackage

// File: rtl/tsca_ripple.sv
module tsca_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  input  logic         c_in,
  output logic [W-1:0] s_out,
  output logic         c_out
);
  logic [W:0] chain;

  assign chain[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s_out[i]   = op_x[i] ^ op_y[i] ^ chain[i];
    assign chain[i+1] = (op_x[i] & op_y[i]) | (chain[i] & (op_x[i] ^ op_y[i]));
  end

  assign c_out = chain[W];
endmodule

// File: rtl/tsca_shared_group.sv
module tsca_shared_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  input  logic         sel_c,
  output logic [W-1:0] s_out,
  output logic         c_out
);
  localparam int RW = W + 1;

  logic [W-1:0]  live_s;
  logic          live_c;
  logic          assumed_c;
  logic [RW-1:0] held;
  logic [RW-1:0] live;

  // high phase assumes carry one, low phase assumes carry zero
  assign assumed_c = clk;

  tsca_ripple #(.W(W)) u_add (
    .op_x  (op_x),
    .op_y  (op_y),
    .c_in  (assumed_c),
    .s_out (live_s),
    .c_out (live_c)
  );

  assign live = {live_c, live_s};

  // transparent while clk is high, holds through the low phase
  always_latch begin
    if (clk) held = live;
  end

  assign {c_out, s_out} = sel_c ? held : live;

  // sampled at the rising edge, i.e. at the end of the low phase
  AST_HELD_IS_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    held == ({1'b0, op_x} + {1'b0, op_y} + RW'(1))); // R3

  AST_LIVE_IS_PLUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    live == ({1'b0, op_x} + {1'b0, op_y})); // R4

  AST_CARRY_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    held[W] >= live[W]); // R5

  AST_SELECT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_c |-> ({c_out, s_out} == ({1'b0, op_x} + {1'b0, op_y} + RW'(1)))); // R5
endmodule

// File: rtl/ts_csel_adder.sv
module ts_csel_adder
  import tsca_pkg::*;
#(
  parameter  int LO_W   = 22,
  parameter  int HI_W   = 10,
  parameter  int NUM_HI = 1,
  localparam int WIDTH  = total_width(LO_W, HI_W, NUM_HI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  // grp_c[g] is the true carry into upper group g; grp_c[NUM_HI] leaves the adder
  logic [NUM_HI:0] grp_c;

  tsca_ripple #(.W(LO_W)) u_low (
    .op_x  (a[LO_W-1:0]),
    .op_y  (b[LO_W-1:0]),
    .c_in  (cin),
    .s_out (sum[LO_W-1:0]),
    .c_out (grp_c[0])
  );

  for (genvar g = 0; g < NUM_HI; g++) begin : g_hi
    localparam int BASE = LO_W + g * HI_W;

    tsca_shared_group #(.W(HI_W)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .op_x  (a[BASE +: HI_W]),
      .op_y  (b[BASE +: HI_W]),
      .sel_c (grp_c[g]),
      .s_out (sum[BASE +: HI_W]),
      .c_out (grp_c[g+1])
    );

    AST_CHAIN_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      grp_c[g+1] == (((HI_W+1)'(a[BASE +: HI_W]) + (HI_W+1)'(b[BASE +: HI_W])
                      + (HI_W+1)'(grp_c[g])) >> HI_W)); // R6
  end

  assign cout = grp_c[NUM_HI];

  AST_LOW_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    {grp_c[0], sum[LO_W-1:0]} == ((LO_W+1)'(a[LO_W-1:0]) + (LO_W+1)'(b[LO_W-1:0])
                                  + (LO_W+1)'(cin))); // R2

  AST_FULL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    {cout, sum} == ((WIDTH+1)'(a) + (WIDTH+1)'(b) + (WIDTH+1)'(cin))); // R1
endmodule

// File: tb/ts_csel_adder_test.sv
`timescale 1ns/1ps
module ts_csel_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        cin = 1'b0;
  logic [31:0] s_two, s_three;
  logic        c_two, c_three;
  int          n_vec = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  // default two-group build: 22 + 10
  ts_csel_adder uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(s_two), .cout(c_two)
  );

  // three-group build: 16 + 8 + 8
  ts_csel_adder #(.LO_W(16), .HI_W(8), .NUM_HI(2)) uut3 (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(s_three), .cout(c_three)
  );

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h", req, a, b, cin, got, exp);
    end
  endtask

  // drive after a rising edge, sample just before the next one
  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic ci,
                       input string req2, input string req3);
    logic [32:0] exp;
    @(posedge clk);
    #1;
    a = x; b = y; cin = ci;
    @(negedge clk);
    #3;
    exp = {1'b0, x} + {1'b0, y} + 33'(ci);
    check(req2, {c_two, s_two}, exp);
    check(req3, {c_three, s_three}, exp);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // reset state: outputs already follow the operands (R1)
    apply(32'h1234_5678, 32'h0FED_CBA9, 1'b1, "R1", "R1");
    apply(32'h0000_0000, 32'h0000_0000, 1'b0, "R1", "R1");
    @(negedge clk);
    rst_n = 1'b1;

    // carry launched at bit 0 that stops exactly at bit p
    for (int p = 0; p <= 32; p++) begin
      logic [31:0] run;
      string t2, t3;
      run = 32'((64'd1 << p) - 64'd1);
      if (p < 22) t2 = "R2";
      else if (p == 22) t2 = "R8";
      else t2 = "R3";
      if (p == 16 || p == 24) t3 = "R8";
      else if (p > 24) t3 = "R6";
      else t3 = "R7";
      apply(run, 32'h0, 1'b1, t2, t3);
      apply(run, 32'h1, 1'b0, t2, t3);
    end

    // all ones plus one wraps with carry out
    apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R6", "R6");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1", "R6");

    // upper groups take the live result: no carry leaves the low group (R4)
    for (int k = 0; k < 64; k++) begin
      logic [31:0] x, y;
      x = {$urandom()} & 32'hFFC0_0000 | ({$urandom()} & 32'h0000_FFFF);
      y = {$urandom()} & 32'hFFC0_0000;
      apply(x, y, 1'b0, "R4", "R7");
    end

    // same upper bits, low carry off then on: both mux inputs (R5)
    for (int k = 0; k < 64; k++) begin
      logic [31:0] hi_x, hi_y;
      hi_x = {$urandom()} & 32'hFFC0_0000;
      hi_y = {$urandom()} & 32'hFFC0_0000;
      apply(hi_x | 32'h003F_FFFF, hi_y, 1'b0, "R5", "R7");
      apply(hi_x | 32'h003F_FFFF, hi_y, 1'b1, "R5", "R7");
    end

    // general random operands
    for (int k = 0; k < 400; k++) begin
      apply($urandom(), $urandom(), 1'($urandom()), "R1", "R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule